// File: doc/BRIEF.md
# Processor Mode and Stack Selector

This block tracks the execution context of a small processor core. It knows whether the core is running ordinary code (Thread mode) or servicing an exception (Handler mode). It also knows whether Thread code runs privileged or unprivileged. It holds two banked stack pointers: a main pointer and a process pointer. A two-bit control register carries a drop-privilege bit (bit 0) and a stack-select bit (bit 1). In Handler mode the core always uses the main pointer and always runs privileged, whatever those bits hold.

The core's sequencer signals exception entry, with an exception number, and exception return. Software writes arrive as strobes for the control register and the stack pointer. The block reports four things:
- the current mode;
- the effective privilege;
- the value of the pointer in use;
- the active exception number.

At reset the main pointer is loaded from the word the fetch logic presents for address zero.

Top module: `ctx_stack_unit`

## Requirements
- R1: While reset is low and after it is released, the block is in Thread mode and privileged. Both control bits read 0, the exception number reads 0, the process pointer is 0, and the active pointer equals `resetSp` with bits [1:0] cleared.
- R2: In Thread mode, control bit 1 picks the active pointer: 0 selects the main pointer and 1 selects the process pointer.
- R3: In Handler mode `activeSp` shows the main pointer and `privileged` is 1, whatever the control bits hold.
- R4: A control write in Handler mode leaves bit 1 unchanged and does take the new value of bit 0.
- R5: In Thread mode, control bit 0 equal to 1 drives `privileged` to 0.
- R6: A control write made while unprivileged leaves bit 0 unchanged, but it still updates bit 1.
- R7: Exception entry takes effect on the next edge: Handler mode, `curExcNum` equal to the entry number, and control bit 1 cleared. A nested entry replaces the number. Entry wins over a return in the same cycle.
- R8: Exception return in Handler mode takes effect on the next edge: Thread mode, `curExcNum` 0, and control bit 1 restored to its value at the last entry from Thread mode. A return in Thread mode has no effect.
- R9: A stack pointer write goes to the pointer active before the clock edge and stores the data with bits [1:0] forced to 0. The other pointer keeps its value.
- R10: A control write made in the same cycle as an entry or a return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetSp | input | DATA_W | Word presented for address 0, loaded into the main pointer during reset |
| excEntry | input | 1 | Exception entry event |
| excNum | input | EXC_W | Exception number for the entry |
| excReturn | input | 1 | Exception return event |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 2 | Control write data: bit 1 stack select, bit 0 drop privilege |
| spWrEn | input | 1 | Stack pointer write strobe |
| spWrData | input | DATA_W | Stack pointer write data |
| inHandler | output | 1 | 1 in Handler mode |
| privileged | output | 1 | Effective privilege |
| activeSp | output | DATA_W | Value of the stack pointer in use |
| curExcNum | output | EXC_W | Active exception number, 0 in Thread mode |
| ctrlOut | output | 2 | Current control register bits |

## Verification
The bench builds the block with a 32-bit data path and a 4-bit exception number. This narrow number field lets random entries reach every number, including 0 and the all-ones value, and makes it likely that nested entries repeat a number. Random data with nonzero low bits exercises the alignment on every pointer write. Random event mixes produce simultaneous entry, return and writes in every mode and privilege combination.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  // strobes from the control half to the pointer datapath
  typedef struct packed {
    logic loadMsp;
    logic loadPsp;
    logic usePsp;
  } dpCtl_t;
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
#(
  parameter int EXC_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excEntry,
  input  logic [EXC_W-1:0] excNum,
  input  logic             excReturn,
  input  logic             ctrlWrEn,
  input  logic [1:0]       ctrlWrData,
  input  logic             spWrEn,
  output dpCtl_t           dpCtl,
  output logic             inHandler,
  output logic             privileged,
  output logic [EXC_W-1:0] curExcNum,
  output logic [1:0]       ctrlBits
);
  logic             handlerQ;
  logic             selQ;
  logic             nPrivQ;
  logic             savedSelQ;
  logic [EXC_W-1:0] excQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      handlerQ  <= 1'b0;
      selQ      <= 1'b0;
      nPrivQ    <= 1'b0;
      savedSelQ <= 1'b0;
      excQ      <= '0;
    end else if (excEntry) begin
      handlerQ <= 1'b1;
      excQ     <= excNum;
      selQ     <= 1'b0;
      if (!handlerQ) savedSelQ <= selQ;
    end else if (excReturn) begin
      if (handlerQ) begin
        handlerQ <= 1'b0;
        excQ     <= '0;
        selQ     <= savedSelQ;
      end
    end else if (ctrlWrEn) begin
      if (!handlerQ) selQ <= ctrlWrData[1];
      if (handlerQ || !nPrivQ) nPrivQ <= ctrlWrData[0];
    end
  end

  always_comb begin
    dpCtl.usePsp  = !handlerQ && selQ;
    dpCtl.loadPsp = spWrEn && dpCtl.usePsp;
    dpCtl.loadMsp = spWrEn && !dpCtl.usePsp;
  end

  assign inHandler  = handlerQ;
  assign privileged = handlerQ || !nPrivQ;
  assign curExcNum  = excQ;
  assign ctrlBits   = {selQ, nPrivQ};
endmodule

// File: rtl/ctx_datapath.sv
module ctx_datapath
  import ctx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] resetSp,
  input  logic [DATA_W-1:0] spWrData,
  input  dpCtl_t            dpCtl,
  output logic [DATA_W-1:0] activeSp
);
  localparam int ALIGN_BITS = 2;
  localparam logic [DATA_W-1:0] ALIGN_MASK = {{(DATA_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [DATA_W-1:0] mspQ;
  logic [DATA_W-1:0] pspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mspQ <= resetSp & ALIGN_MASK;
      pspQ <= '0;
    end else begin
      if (dpCtl.loadMsp) mspQ <= spWrData & ALIGN_MASK;
      if (dpCtl.loadPsp) pspQ <= spWrData & ALIGN_MASK;
    end
  end

  assign activeSp = dpCtl.usePsp ? pspQ : mspQ;
endmodule

// File: rtl/ctx_stack_unit.sv
module ctx_stack_unit
  import ctx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXC_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] resetSp,
  input  logic              excEntry,
  input  logic [EXC_W-1:0]  excNum,
  input  logic              excReturn,
  input  logic              ctrlWrEn,
  input  logic [1:0]        ctrlWrData,
  input  logic              spWrEn,
  input  logic [DATA_W-1:0] spWrData,
  output logic              inHandler,
  output logic              privileged,
  output logic [DATA_W-1:0] activeSp,
  output logic [EXC_W-1:0]  curExcNum,
  output logic [1:0]        ctrlOut
);
  dpCtl_t dpCtl;

  ctx_ctrl #(.EXC_W(EXC_W)) ctrlU (
    .clk(clk), .rstN(rstN), .excEntry(excEntry), .excNum(excNum),
    .excReturn(excReturn), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .spWrEn(spWrEn), .dpCtl(dpCtl), .inHandler(inHandler),
    .privileged(privileged), .curExcNum(curExcNum), .ctrlBits(ctrlOut)
  );

  ctx_datapath #(.DATA_W(DATA_W)) dpU (
    .clk(clk), .rstN(rstN), .resetSp(resetSp), .spWrData(spWrData),
    .dpCtl(dpCtl), .activeSp(activeSp)
  );
endmodule

// File: rtl/ctx_check.sv
module ctx_check #(
  parameter int DATA_W = 32,
  parameter int EXC_W  = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              excEntry,
  input logic [EXC_W-1:0]  excNum,
  input logic              excReturn,
  input logic              inHandler,
  input logic              privileged,
  input logic [DATA_W-1:0] activeSp,
  input logic [EXC_W-1:0]  curExcNum,
  input logic [1:0]        ctrlOut
);
  assert_handler_priv_R3: assert property (@(posedge clk) disable iff (!rstN)
    inHandler |-> privileged);

  assert_unpriv_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!inHandler && ctrlOut[0]) |-> !privileged);

  assert_sel_locked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inHandler && !excReturn) |=> (ctrlOut[1] == $past(ctrlOut[1])));

  assert_npriv_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !privileged |=> ctrlOut[0]);

  assert_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    excEntry |=> (inHandler && curExcNum == $past(excNum) && !ctrlOut[1]));

  assert_return_R8: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !excEntry && inHandler) |=> (!inHandler && curExcNum == '0));

  assert_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    activeSp[1:0] == 2'b00);
endmodule

bind ctx_stack_unit ctx_check #(.DATA_W(DATA_W), .EXC_W(EXC_W)) chkU (
  .clk(clk), .rstN(rstN), .excEntry(excEntry), .excNum(excNum),
  .excReturn(excReturn), .inHandler(inHandler), .privileged(privileged),
  .activeSp(activeSp), .curExcNum(curExcNum), .ctrlOut(ctrlOut)
);

// File: tb/ctx_stack_unit_test.sv
module ctx_stack_unit_test;
  localparam int DW = 32;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] resetSp = 32'h2000_7FFF;
  logic          excEntry = 1'b0;
  logic [EW-1:0] excNum = '0;
  logic          excReturn = 1'b0;
  logic          ctrlWrEn = 1'b0;
  logic [1:0]    ctrlWrData = '0;
  logic          spWrEn = 1'b0;
  logic [DW-1:0] spWrData = '0;
  logic          inHandler, privileged;
  logic [DW-1:0] activeSp;
  logic [EW-1:0] curExcNum;
  logic [1:0]    ctrlOut;

  int vectors = 0;
  int fails = 0;

  // reference model state
  logic          mH, mSel, mNp, mSaved;
  logic [DW-1:0] mMsp, mPsp;
  logic [EW-1:0] mExc;

  always #5 clk = ~clk;

  ctx_stack_unit #(.DATA_W(DW), .EXC_W(EW)) uut (
    .clk(clk), .rstN(rstN), .resetSp(resetSp), .excEntry(excEntry),
    .excNum(excNum), .excReturn(excReturn), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .spWrEn(spWrEn), .spWrData(spWrData),
    .inHandler(inHandler), .privileged(privileged), .activeSp(activeSp),
    .curExcNum(curExcNum), .ctrlOut(ctrlOut)
  );

  function automatic logic [DW-1:0] expActive();
    return (!mH && mSel) ? mPsp : mMsp;   // R2, R3
  endfunction

  function automatic logic expPriv();
    return mH || !mNp;                    // R3, R5
  endfunction

  function automatic logic [DW-1:0] aligned(input logic [DW-1:0] v);
    return {v[DW-1:2], 2'b00};            // R9
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    cmp(req, "inHandler", DW'(inHandler), DW'(mH));
    cmp(req, "privileged", DW'(privileged), DW'(expPriv()));
    cmp(req, "activeSp", activeSp, expActive());
    cmp(req, "curExcNum", DW'(curExcNum), DW'(mExc));
    cmp(req, "ctrlOut", DW'(ctrlOut), DW'({mSel, mNp}));
  endtask

  task automatic modelUpdate();
    logic usePsp;
    usePsp = !mH && mSel;
    if (spWrEn) begin                     // R9
      if (usePsp) mPsp = aligned(spWrData);
      else        mMsp = aligned(spWrData);
    end
    if (excEntry) begin                   // R7
      if (!mH) mSaved = mSel;
      mH = 1'b1; mExc = excNum; mSel = 1'b0;
    end else if (excReturn) begin         // R8, R10
      if (mH) begin mH = 1'b0; mExc = '0; mSel = mSaved; end
    end else if (ctrlWrEn) begin          // R4, R6
      if (!mH) mSel = ctrlWrData[1];
      if (mH || !mNp) mNp = ctrlWrData[0];
    end
  endtask

  task automatic step(input string req, input logic en, input logic [EW-1:0] num,
                      input logic ret, input logic cwe, input logic [1:0] cwd,
                      input logic swe, input logic [DW-1:0] swd);
    @(negedge clk);
    checkAll(req);
    excEntry = en; excNum = num; excReturn = ret;
    ctrlWrEn = cwe; ctrlWrData = cwd; spWrEn = swe; spWrData = swd;
    @(posedge clk);
    #1 modelUpdate();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1DE5_0A7B));
    mH = 0; mSel = 0; mNp = 0; mSaved = 0; mExc = '0;
    mMsp = aligned(resetSp); mPsp = '0;
    repeat (3) @(negedge clk);
    checkAll("R1");                                    // R1 during reset
    rstN = 1'b1;
    // R1 checked at start of first step
    step("R1", 0, 0, 0, 1, 2'b10, 0, 0);               // R2 select process
    step("R2", 0, 0, 0, 0, 2'b00, 1, 32'h1000_1237);   // R9 write to process ptr
    step("R9", 1, 4'd5, 0, 0, 2'b00, 0, 0);            // R7 entry
    step("R7", 0, 0, 0, 1, 2'b10, 0, 0);               // R4 select ignored
    step("R4", 0, 0, 0, 0, 2'b00, 1, 32'h2000_0FF1);   // R3/R9 handler -> main
    step("R3", 1, 4'd15, 0, 0, 2'b00, 0, 0);           // R7 nested entry
    step("R7", 0, 0, 1, 0, 2'b00, 0, 0);               // R8 return restores select
    step("R8", 0, 0, 1, 1, 2'b00, 0, 0);               // R8/R10 return in thread
    step("R10", 0, 0, 0, 1, 2'b11, 0, 0);              // R5 drop privilege
    step("R5", 0, 0, 0, 1, 2'b00, 0, 0);               // R6 cannot regain
    step("R6", 1, 4'd0, 1, 1, 2'b01, 0, 0);            // R7/R10 entry beats return
    step("R10", 0, 0, 0, 1, 2'b00, 0, 0);              // R4 handler clears bit 0
    step("R4", 0, 0, 1, 0, 2'b00, 0, 0);               // R8 return
    for (int i = 0; i < 4000; i++) begin
      step("R2/R3/R7/R8/R9 random",
           ($urandom % 8) == 0, EW'($urandom), ($urandom % 6) == 0,
           ($urandom % 3) == 0, 2'($urandom), ($urandom % 3) == 0, $urandom);
    end
    step("R9 final", 0, 0, 0, 0, 2'b00, 0, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule